// File: doc/BRIEF.md
# Reset and Boot Mode Sensing Unit

This unit watches two device pins, the active-high reset request and the active-low program-store strobe, on the oscillator clock. It uses a machine-cycle tick from the clock generator to time how long the reset request stays high. Once the request has been high for long enough it drives a device reset. When the request is released, it decides whether the device starts in normal operation or in an external-host programming mode.

Host mode is chosen only if a high-to-low transition of the strobe pin was seen while the reset request was high, and only if that request then stayed high for more than the host threshold of machine cycles without a break. A strobe edge while the reset request is low has no effect. A reset request too short to count as a device reset leaves the stored mode alone. Both pins pass through multi-flop synchronizers before any edge is detected. The count of machine cycles saturates instead of wrapping, so however long the reset request is held, the result does not change.

Top module: `boot_mode_sense`

## Requirements
- R1: After the power-on clear `por_ni` is released, `dev_rst_o` is 0 and `host_mode_o` is 0 (0 = normal operation, 1 = external-host mode).
- R2: `dev_rst_o` rises once the synchronized reset request has been high across `RST_CYC` (default 2) machine-cycle ticks. With fewer ticks it stays 0.
- R3: Both pins pass through `SYNC_STAGES` (default 2, at least 2) flops. `dev_rst_o` returns to 0 within `SYNC_STAGES`+2 clocks after `rst_pin_i` falls.
- R4: A strobe falling edge while the synchronized reset request is high, followed by that request staying high for more than `HOST_CYC` (default 10) ticks, sets `host_mode_o` to 1 after release.
- R5: If the reset request is held for exactly `HOST_CYC` ticks, a strobe edge during it still gives `host_mode_o` = 0 after release.
- R6: A qualifying reset (at least `RST_CYC` ticks) with no strobe falling edge inside it gives `host_mode_o` = 0 after release, including when the strobe is held low for the whole reset.
- R7: A strobe falling edge while the reset request is low leaves `host_mode_o` unchanged. It also does not count toward a later reset.
- R8: `host_mode_o` changes only when a qualifying reset is released. A reset request shorter than `RST_CYC` ticks leaves it unchanged.
- R9: The tick count saturates while the reset request is held. A hold far past the counter's range still selects host mode after a strobe edge, and `dev_rst_o` stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_ni | input | 1 | Asynchronous power-on clear, active low |
| mc_tick_i | input | 1 | One-clock pulse per machine cycle |
| rst_pin_i | input | 1 | Reset request pin, active high, asynchronous |
| psen_pin_ni | input | 1 | Program-store strobe pin, active low, asynchronous |
| dev_rst_o | output | 1 | Device reset, high while a qualifying reset is held |
| host_mode_o | output | 1 | Boot mode flag: 0 normal, 1 external host |

## Verification
The hardest case to reach from the ports is a reset hold long enough to run the tick counter past the value at which a wrapping counter would return to zero. Only then does the difference between saturation and wrap show up in the mode decision. The bench holds the reset request for twenty ticks with a strobe edge near the start and expects host mode. It also places a strobe edge just before a reset request and holds the strobe low through a full reset. Together these show that only an edge inside the window counts.

// File: rtl/boot_sense_pkg.sv
package boot_sense_pkg;

   typedef enum logic {
      BOOT_NORMAL = 1'b0,
      BOOT_HOST   = 1'b1
   } boot_mode_e;

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/bs_sync.sv
module bs_sync #(
   parameter int   STAGES   = 2,
   parameter logic INIT_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge por_ni) begin
               if (!por_ni) chain_q[0] <= INIT_VAL;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge por_ni) begin
               if (!por_ni) chain_q[s] <= INIT_VAL;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bs_hold_cnt.sv
module bs_hold_cnt
   import boot_sense_pkg::*;
#(
   parameter int RST_CYC  = 2,
   parameter int HOST_CYC = 10
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic tick_i,
   input  logic rst_s_i,
   output logic qual_o,
   output logic long_o
);

   localparam int CNT_MAX = HOST_CYC + 1;
   localparam int CW      = cnt_width(CNT_MAX);

   generate
      if (RST_CYC < 1) begin : g_bad_rst
         $error("bs_hold_cnt: RST_CYC must be at least 1");
      end
      if (HOST_CYC < RST_CYC) begin : g_bad_host
         $error("bs_hold_cnt: HOST_CYC must not be below RST_CYC");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          at_max;

   assign at_max = (cnt_q == CW'(CNT_MAX));

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)             cnt_q <= '0;
      else if (!rst_s_i)       cnt_q <= '0;
      else if (tick_i && !at_max) cnt_q <= cnt_q + 1'b1;
   end

   assign qual_o = (cnt_q >= CW'(RST_CYC));
   assign long_o = at_max;

   // R9: a saturated count stays put while the request is held
   a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!por_ni)
      (at_max && rst_s_i) |=> at_max);

   // R8: a released request empties the count
   a_r8_cnt_clear: assert property (@(posedge clk_i) disable iff (!por_ni)
      !rst_s_i |=> (cnt_q == '0));

   // R2: the count only moves on a tick
   a_r2_tick_only: assert property (@(posedge clk_i) disable iff (!por_ni)
      (rst_s_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/bs_mode_latch.sv
module bs_mode_latch
   import boot_sense_pkg::*;
(
   input  logic       clk_i,
   input  logic       por_ni,
   input  logic       rst_s_i,
   input  logic       psen_s_ni,
   input  logic       qual_i,
   input  logic       long_i,
   output boot_mode_e mode_o,
   output logic       dev_rst_o
);

   logic       rst_d_q;
   logic       psen_d_q;
   logic       host_req_q;
   logic       dev_rst_q;
   boot_mode_e mode_q;
   logic       psen_fall;
   logic       rst_fall;

   assign psen_fall = psen_d_q && !psen_s_ni;
   assign rst_fall  = rst_d_q && !rst_s_i;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         rst_d_q  <= 1'b0;
         psen_d_q <= 1'b1;
      end else begin
         rst_d_q  <= rst_s_i;
         psen_d_q <= psen_s_ni;
      end
   end

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)                  host_req_q <= 1'b0;
      else if (!rst_s_i)            host_req_q <= 1'b0;
      else if (psen_fall)           host_req_q <= 1'b1;
   end

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         mode_q <= BOOT_NORMAL;
      end else if (rst_fall && qual_i) begin
         mode_q <= (host_req_q && long_i) ? BOOT_HOST : BOOT_NORMAL;
      end
   end

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) dev_rst_q <= 1'b0;
      else         dev_rst_q <= rst_s_i && qual_i;
   end

   assign mode_o    = mode_q;
   assign dev_rst_o = dev_rst_q;

   // R8: mode moves only at the release of a qualifying reset
   a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!por_ni)
      !(rst_fall && qual_i) |=> $stable(mode_q));

   // R7: no pending host request survives a low request
   a_r7_req_clear: assert property (@(posedge clk_i) disable iff (!por_ni)
      !rst_s_i |=> !host_req_q);

   // R3: device reset drops once the request is low
   a_r3_rst_drop: assert property (@(posedge clk_i) disable iff (!por_ni)
      !rst_s_i |=> !dev_rst_q);

   // R5: host mode requires a long hold at release
   a_r5_long_needed: assert property (@(posedge clk_i) disable iff (!por_ni)
      (rst_fall && !long_i) |=> (mode_q == BOOT_NORMAL || $stable(mode_q)));

endmodule

// File: rtl/boot_mode_sense.sv
module boot_mode_sense
   import boot_sense_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYC     = 2,
   parameter int HOST_CYC    = 10
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic mc_tick_i,
   input  logic rst_pin_i,
   input  logic psen_pin_ni,
   output logic dev_rst_o,
   output logic host_mode_o
);

   logic       rst_s;
   logic       psen_s_n;
   logic       qual;
   logic       long_hold;
   boot_mode_e mode;

   bs_sync #(.STAGES(SYNC_STAGES), .INIT_VAL(1'b0)) i_rst_sync (
      .clk_i  (clk_i),
      .por_ni (por_ni),
      .d_i    (rst_pin_i),
      .q_o    (rst_s)
   );

   bs_sync #(.STAGES(SYNC_STAGES), .INIT_VAL(1'b1)) i_psen_sync (
      .clk_i  (clk_i),
      .por_ni (por_ni),
      .d_i    (psen_pin_ni),
      .q_o    (psen_s_n)
   );

   bs_hold_cnt #(.RST_CYC(RST_CYC), .HOST_CYC(HOST_CYC)) i_cnt (
      .clk_i   (clk_i),
      .por_ni  (por_ni),
      .tick_i  (mc_tick_i),
      .rst_s_i (rst_s),
      .qual_o  (qual),
      .long_o  (long_hold)
   );

   bs_mode_latch i_latch (
      .clk_i     (clk_i),
      .por_ni    (por_ni),
      .rst_s_i   (rst_s),
      .psen_s_ni (psen_s_n),
      .qual_i    (qual),
      .long_i    (long_hold),
      .mode_o    (mode),
      .dev_rst_o (dev_rst_o)
   );

   assign host_mode_o = (mode == BOOT_HOST);

   // R2: device reset only while the synchronized request is high
   a_r2_rst_follows: assert property (@(posedge clk_i) disable iff (!por_ni)
      dev_rst_o |-> $past(rst_s));

   // R1: outputs are defined once the clear is released
   a_r1_known: assert property (@(posedge clk_i) disable iff (!por_ni)
      !$isunknown({dev_rst_o, host_mode_o}));

endmodule

// File: tb/test_boot_mode_sense.sv
module test_boot_mode_sense;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic tick = 1'b0;
   logic rst_pin = 1'b0;
   logic psen_n = 1'b1;
   logic dev_rst;
   logic host_mode;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   boot_mode_sense i_boot_mode_sense (
      .clk_i       (clk),
      .por_ni      (por_n),
      .mc_tick_i   (tick),
      .rst_pin_i   (rst_pin),
      .psen_pin_ni (psen_n),
      .dev_rst_o   (dev_rst),
      .host_mode_o (host_mode)
   );

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic one_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      wait_clk(2);
   endtask

   // hold reset for n ticks; drop strobe before tick edge_at (if >=0)
   task automatic hold_reset(input int n, input int edge_at);
      @(negedge clk); rst_pin = 1'b1;
      wait_clk(4);
      for (int k = 0; k < n; k++) begin
         if (k == edge_at) begin
            psen_n = 1'b0;
            wait_clk(4);
         end
         one_tick();
      end
   endtask

   task automatic release_reset();
      @(negedge clk); rst_pin = 1'b0;
      wait_clk(6);
      psen_n = 1'b1;
      wait_clk(4);
   endtask

   task automatic t_reset_state();
      check("R1 dev_rst after clear", dev_rst, 1'b0);
      check("R1 mode after clear", host_mode, 1'b0);
   endtask

   task automatic t_dev_rst_timing();
      @(negedge clk); rst_pin = 1'b1;
      wait_clk(4);
      check("R2 no reset before ticks", dev_rst, 1'b0);
      one_tick();
      check("R2 no reset after one tick", dev_rst, 1'b0);
      one_tick();
      check("R2 reset after two ticks", dev_rst, 1'b1);
      @(negedge clk); rst_pin = 1'b0;
      wait_clk(4);
      check("R3 reset drops after release", dev_rst, 1'b0);
      wait_clk(4);
   endtask

   task automatic t_host_entry();
      hold_reset(12, 1);
      check("R4 reset held during long hold", dev_rst, 1'b1);
      release_reset();
      check("R4 host mode after long hold with edge", host_mode, 1'b1);
   endtask

   task automatic t_short_reset_keeps();
      hold_reset(1, 0);
      check("R8 short hold gives no reset", dev_rst, 1'b0);
      release_reset();
      check("R8 short hold keeps host mode", host_mode, 1'b1);
   endtask

   task automatic t_no_edge();
      hold_reset(12, -1);
      release_reset();
      check("R6 normal without edge", host_mode, 1'b0);
   endtask

   task automatic t_exact_threshold();
      hold_reset(11, 0);
      release_reset();
      check("R4 host at threshold plus one", host_mode, 1'b1);
      hold_reset(10, 0);
      release_reset();
      check("R5 normal at exactly threshold", host_mode, 1'b0);
   endtask

   task automatic t_edge_while_low();
      @(negedge clk); psen_n = 1'b0;
      wait_clk(5);
      check("R7 edge while low leaves mode", host_mode, 1'b0);
      psen_n = 1'b1;
      wait_clk(5);
      psen_n = 1'b0;
      wait_clk(5);
      hold_reset(12, -1);
      release_reset();
      check("R6 strobe low through reset gives normal", host_mode, 1'b0);
      // edge just before the request, then strobe back high during it
      @(negedge clk); psen_n = 1'b0;
      wait_clk(5);
      psen_n = 1'b1;
      hold_reset(12, -1);
      release_reset();
      check("R7 edge before reset ignored", host_mode, 1'b0);
   endtask

   task automatic t_saturate();
      hold_reset(20, 1);
      check("R9 reset stays high on long hold", dev_rst, 1'b1);
      release_reset();
      check("R9 host after very long hold", host_mode, 1'b1);
   endtask

   initial begin
      wait_clk(3);
      por_n = 1'b1;
      wait_clk(3);
      t_reset_state();
      t_dev_rst_timing();
      check("R6 normal after edgeless qualifying reset", host_mode, 1'b0);
      t_host_entry();
      t_short_reset_keeps();
      t_no_edge();
      t_exact_threshold();
      t_edge_while_low();
      t_saturate();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=done");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule